// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level translation table held in memory. The address is cut into a 10-bit top index, a 10-bit middle index and a 12-bit byte offset. The top index picks an entry in the first-level table. That table starts at a base address, and a length value limits how many entries it has. The chosen entry points to a second-level table, and the middle index picks an entry there. That entry supplies the frame number. The frame number placed above the untouched offset forms the physical address.

A requester hands over one address at a time through a valid/ready port and gets back either a physical address or a fault code. Toward memory the block has a read-request port with valid/ready and a response port. It keeps at most one read outstanding, and it never has more than one walk in flight.

The controller has five states. ST_IDLE accepts a request. It goes to ST_READ_OUTER if the top index is inside the table, and to ST_FAULT if it is not. ST_READ_OUTER issues the first-level read and waits for the data. It goes to ST_READ_INNER on a valid entry and to ST_FAULT otherwise. ST_READ_INNER issues the second-level read. It goes to ST_DONE on a usable entry and to ST_FAULT on an invalid entry or a refused write. ST_DONE and ST_FAULT hold the response until it is taken, then return to ST_IDLE.

Top module: `pt_walker`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, while `resp_valid` and `mem_rd_valid` are both 0.
- R2: The first memory read of a walk goes to `tbl_base + 4*vaddr[31:22]`. The base and the length are sampled when the request is accepted.
- R3: If `vaddr[31:22]` is greater than or equal to `tbl_len`, no memory read is issued. The fault response is valid in the cycle after acceptance, with `resp_kind` = 0 (length). The boundary index `tbl_len-1` walks normally.
- R4: A first-level entry whose bit 0 (valid) is 0 ends the walk after one read, with `resp_kind` = 1.
- R5: The second read goes to `{first_entry[31:12], 12'h000} + 4*vaddr[21:12]`.
- R6: A second-level entry whose bit 0 is 0 ends the walk with `resp_kind` = 2.
- R7: A successful walk returns `resp_fault` = 0 and `resp_paddr = {second_entry[31:12], vaddr[11:0]}`.
- R8: When `req_write` = 1 and bit 1 (writable) of the second-level entry is 0, the walk faults with `resp_kind` = 3. The writable bit has no effect on reads, and bit 1 of the first-level entry is never checked.
- R9: `mem_rd_valid` and `mem_rd_addr` stay stable until `mem_rd_ready` is seen. No new read is raised until the response to the current read has arrived.
- R10: `resp_valid` and the response fields stay stable until `resp_ready` is 1. `req_ready` is 0 from acceptance until the response is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A translation request is offered |
| req_ready | output | 1 | The block can accept a request (idle) |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | The access is a write |
| tbl_base | input | 32 | Byte address of the first-level table |
| tbl_len | input | 11 | Number of first-level entries in use |
| mem_rd_valid | output | 1 | Read request toward memory |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | 32 | Table entry read from memory |
| resp_valid | output | 1 | Translation result is present |
| resp_ready | input | 1 | Requester takes the result |
| resp_fault | output | 1 | The walk failed |
| resp_kind | output | 2 | Fault cause: 0 length, 1 first-level invalid, 2 second-level invalid, 3 write refused |
| resp_paddr | output | 32 | Physical address on success, 0 on fault |

## Verification
The embedded properties assume well-behaved memory. `mem_rsp_valid` is raised only while a read is outstanding, and only in a cycle after that read was accepted. Each read gets exactly one response pulse, and no data comes back for a read that was never issued. The bench's memory model keeps to these rules. It handles one read at a time: it records the address, optionally stalls `mem_rd_ready`, waits a programmable latency, and then drives a single response cycle. Requests are offered only while the block is idle.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_OUTER,
        ST_READ_INNER,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    typedef enum logic [1:0] {
        FK_LENGTH        = 2'd0,
        FK_OUTER_INVALID = 2'd1,
        FK_INNER_INVALID = 2'd2,
        FK_WRITE_DENIED  = 2'd3
    } fault_kind_e;

    localparam int ENTRY_VALID_BIT = 0;
    localparam int ENTRY_WRITE_BIT = 1;
    localparam int ENTRY_BYTES_LOG2 = 2;

endpackage

// File: rtl/pt_va_split.sv
module pt_va_split #(
    parameter int VA_W  = 32,
    parameter int OUT_W = 10,
    parameter int IN_W  = 10,
    parameter int OFF_W = 12
) (
    input  logic [VA_W-1:0]  va,
    output logic [OUT_W-1:0] outer_idx,
    output logic [IN_W-1:0]  inner_idx,
    output logic [OFF_W-1:0] offset
);
    localparam int IN_LSB  = OFF_W;
    localparam int OUT_LSB = OFF_W + IN_W;

    assign offset    = va[OFF_W-1:0];
    assign inner_idx = va[IN_LSB +: IN_W];
    assign outer_idx = va[OUT_LSB +: OUT_W];

endmodule

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int SHIFT  = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    localparam int PAD_W = ADDR_W - IDX_W;

    logic [ADDR_W-1:0] idx_wide;

    assign idx_wide = {{PAD_W{1'b0}}, idx};
    assign addr     = base + (idx_wide << SHIFT);

endmodule

// File: rtl/pt_entry_decode.sv
module pt_entry_decode #(
    parameter int ENTRY_W = 32,
    parameter int OFF_W   = 12
) (
    input  logic [ENTRY_W-1:0]       entry,
    output logic                     ent_valid,
    output logic                     ent_writable,
    output logic [ENTRY_W-OFF_W-1:0] ent_base
);
    import pt_walk_pkg::*;

    logic unused_entry_bits;

    assign ent_valid         = entry[ENTRY_VALID_BIT];
    assign ent_writable      = entry[ENTRY_WRITE_BIT];
    assign ent_base          = entry[ENTRY_W-1:OFF_W];
    assign unused_entry_bits = ^entry[OFF_W-1:ENTRY_WRITE_BIT+1];

endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl #(
    parameter int ADDR_W = 32,
    parameter int OUT_W  = 10,
    parameter int OFF_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_va,
    input  logic [OUT_W-1:0]        req_outer_idx,
    input  logic [ADDR_W-1:0]       tbl_base,
    input  logic [OUT_W:0]          tbl_len,
    input  logic                    mem_rd_ready,
    input  logic                    mem_rsp_valid,
    input  logic                    ent_valid,
    input  logic                    ent_writable,
    input  logic [ADDR_W-OFF_W-1:0] ent_base,
    input  logic                    resp_ready,
    output logic                    req_ready,
    output logic                    mem_rd_valid,
    output logic                    sel_inner,
    output logic [ADDR_W-1:0]       lvl_base,
    output logic [ADDR_W-1:0]       va_held,
    output logic                    resp_valid,
    output logic                    resp_fault,
    output logic [1:0]              resp_kind,
    output logic [ADDR_W-1:0]       resp_paddr
);
    import pt_walk_pkg::*;

    localparam int BASE_W = ADDR_W - OFF_W;

    walk_state_e       state_q, state_d;
    fault_kind_e       kind_q;
    logic [ADDR_W-1:0] va_q;
    logic [ADDR_W-1:0] lvl_base_q;
    logic [BASE_W-1:0] frame_q;
    logic              wr_q;
    logic              issued_q;
    logic              rsp_hit;
    logic              len_ok;
    logic              wr_refused;

    assign rsp_hit    = issued_q && mem_rsp_valid;
    assign len_ok     = {1'b0, req_outer_idx} < tbl_len;
    assign wr_refused = wr_q && !ent_writable;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = len_ok ? ST_READ_OUTER : ST_FAULT;
            end
            ST_READ_OUTER: begin
                if (rsp_hit) state_d = ent_valid ? ST_READ_INNER : ST_FAULT;
            end
            ST_READ_INNER: begin
                if (rsp_hit) state_d = (!ent_valid || wr_refused) ? ST_FAULT : ST_DONE;
            end
            ST_DONE, ST_FAULT: begin
                if (resp_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // walk context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q       <= '0;
            wr_q       <= 1'b0;
            lvl_base_q <= '0;
            frame_q    <= '0;
            issued_q   <= 1'b0;
            kind_q     <= FK_LENGTH;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q       <= req_va;
                        wr_q       <= req_write;
                        lvl_base_q <= tbl_base;
                        issued_q   <= 1'b0;
                        kind_q     <= FK_LENGTH;
                    end
                end
                ST_READ_OUTER: begin
                    if (mem_rd_valid && mem_rd_ready) issued_q <= 1'b1;
                    if (rsp_hit) begin
                        issued_q   <= 1'b0;
                        lvl_base_q <= {ent_base, {OFF_W{1'b0}}};
                        kind_q     <= FK_OUTER_INVALID;
                    end
                end
                ST_READ_INNER: begin
                    if (mem_rd_valid && mem_rd_ready) issued_q <= 1'b1;
                    if (rsp_hit) begin
                        issued_q <= 1'b0;
                        frame_q  <= ent_base;
                        kind_q   <= !ent_valid ? FK_INNER_INVALID : FK_WRITE_DENIED;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        mem_rd_valid = ((state_q == ST_READ_OUTER) || (state_q == ST_READ_INNER)) && !issued_q;
        sel_inner    = (state_q == ST_READ_INNER);
        lvl_base     = lvl_base_q;
        va_held      = va_q;
        resp_valid   = (state_q == ST_DONE) || (state_q == ST_FAULT);
        resp_fault   = (state_q == ST_FAULT);
        resp_kind    = (state_q == ST_FAULT) ? kind_q : 2'd0;
        resp_paddr   = (state_q == ST_DONE) ? {frame_q, va_q[OFF_W-1:0]} : '0;
    end

    // input assumption: data only returns for an accepted read (R9)
    assert_rsp_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> (issued_q && ((state_q == ST_READ_OUTER) || (state_q == ST_READ_INNER))));

    assert_len_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && ({1'b0, req_outer_idx} >= tbl_len))
        |=> (resp_valid && resp_fault && (resp_kind == FK_LENGTH) && !mem_rd_valid));

    assert_outer_invalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_READ_OUTER) && rsp_hit && !ent_valid)
        |=> (resp_valid && resp_fault && (resp_kind == FK_OUTER_INVALID)));

    assert_resp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready)
        |=> (resp_valid && $stable(resp_fault) && $stable(resp_kind) && $stable(resp_paddr)));

    assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
    parameter int ADDR_W = 32,
    parameter int OUT_W  = 10,
    parameter int IN_W   = 10,
    parameter int OFF_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [OUT_W:0]    tbl_len,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              resp_valid,
    input  logic              resp_ready,
    output logic              resp_fault,
    output logic [1:0]        resp_kind,
    output logic [ADDR_W-1:0] resp_paddr
);
    import pt_walk_pkg::*;

    localparam int BASE_W  = ADDR_W - OFF_W;
    localparam int IDX_W   = (OUT_W > IN_W) ? OUT_W : IN_W;
    localparam int OUT_LSB = OFF_W + IN_W;

    logic [OUT_W-1:0]  req_outer_idx;
    logic [OUT_W-1:0]  outer_idx_q;
    logic [IN_W-1:0]   inner_idx_q;
    logic [OFF_W-1:0]  offset_q;
    logic [ADDR_W-1:0] va_held;
    logic [ADDR_W-1:0] lvl_base;
    logic              sel_inner;
    logic [IDX_W-1:0]  cur_idx;
    logic              ent_valid;
    logic              ent_writable;
    logic [BASE_W-1:0] ent_base;

    assign req_outer_idx = req_vaddr[OUT_LSB +: OUT_W];

    pt_va_split #(
        .VA_W (ADDR_W),
        .OUT_W(OUT_W),
        .IN_W (IN_W),
        .OFF_W(OFF_W)
    ) split_i (
        .va       (va_held),
        .outer_idx(outer_idx_q),
        .inner_idx(inner_idx_q),
        .offset   (offset_q)
    );

    assign cur_idx = sel_inner ? IDX_W'(inner_idx_q) : IDX_W'(outer_idx_q);

    pt_entry_addr #(
        .ADDR_W(ADDR_W),
        .IDX_W (IDX_W),
        .SHIFT (ENTRY_BYTES_LOG2)
    ) addr_i (
        .base(lvl_base),
        .idx (cur_idx),
        .addr(mem_rd_addr)
    );

    pt_entry_decode #(
        .ENTRY_W(ADDR_W),
        .OFF_W  (OFF_W)
    ) decode_i (
        .entry       (mem_rsp_data),
        .ent_valid   (ent_valid),
        .ent_writable(ent_writable),
        .ent_base    (ent_base)
    );

    pt_walk_ctrl #(
        .ADDR_W(ADDR_W),
        .OUT_W (OUT_W),
        .OFF_W (OFF_W)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_va       (req_vaddr),
        .req_outer_idx(req_outer_idx),
        .tbl_base     (tbl_base),
        .tbl_len      (tbl_len),
        .mem_rd_ready (mem_rd_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .ent_valid    (ent_valid),
        .ent_writable (ent_writable),
        .ent_base     (ent_base),
        .resp_ready   (resp_ready),
        .req_ready    (req_ready),
        .mem_rd_valid (mem_rd_valid),
        .sel_inner    (sel_inner),
        .lvl_base     (lvl_base),
        .va_held      (va_held),
        .resp_valid   (resp_valid),
        .resp_fault   (resp_fault),
        .resp_kind    (resp_kind),
        .resp_paddr   (resp_paddr)
    );

    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    assert_offset_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_fault) |-> (resp_paddr[OFF_W-1:0] == offset_q));

    assert_fault_no_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> (resp_paddr == '0));

endmodule

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [31:0] tbl_base = 32'h0001_0000;
    logic [10:0] tbl_len = 11'd16;
    logic        mem_rd_valid;
    logic        mem_rd_ready;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        resp_valid;
    logic        resp_ready = 1'b0;
    logic        resp_fault;
    logic [1:0]  resp_kind;
    logic [31:0] resp_paddr;

    int errors = 0;
    int checks = 0;
    int rd_count = 0;
    logic [31:0] rd_log [4];
    int ready_delay = 0;
    int rsp_delay = 0;
    logic [31:0] mem_img [logic [31:0]];

    always #4 clk = ~clk;

    pt_walker dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
        .tbl_base(tbl_base), .tbl_len(tbl_len),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_fault(resp_fault),
        .resp_kind(resp_kind), .resp_paddr(resp_paddr)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mem_read(input logic [31:0] a);
        if (mem_img.exists(a)) return mem_img[a];
        return 32'h0;
    endfunction

    // memory model: one read at a time, optional ready stall and latency
    initial begin
        mem_rd_ready  = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            mem_rd_ready  = 1'b0;
            mem_rsp_valid = 1'b0;
            if (rst_n && mem_rd_valid) begin
                logic [31:0] a;
                a = mem_rd_addr;
                if (rd_count < 4) rd_log[rd_count] = a;
                rd_count++;
                for (int i = 0; i < ready_delay; i++) begin
                    @(negedge clk);
                    check(mem_rd_valid && (mem_rd_addr == a), "R9 read held while stalled", mem_rd_addr, a);
                end
                mem_rd_ready = 1'b1;
                @(negedge clk);
                mem_rd_ready = 1'b0;
                for (int i = 0; i < rsp_delay; i++) begin
                    @(negedge clk);
                    check(!mem_rd_valid, "R9 no second read outstanding", {31'b0, mem_rd_valid}, 32'h0);
                end
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_read(a);
            end
        end
    end

    task automatic run_walk(input string req, input logic [31:0] va, input logic wr,
                            input logic exp_fault, input logic [1:0] exp_kind, input logic [31:0] exp_pa,
                            input int exp_reads, input logic [31:0] a0, input logic [31:0] a1,
                            input int hold);
        int n;
        rd_count = 0;
        @(negedge clk);
        req_vaddr = va;
        req_write = wr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R10 busy after accept", {31'b0, req_ready}, 32'h0);
        if (exp_reads == 0)
            check(resp_valid && !mem_rd_valid, "R3 immediate fault", {30'b0, resp_valid, mem_rd_valid}, 32'h2);
        n = 0;
        while (!resp_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(resp_fault == exp_fault, {req, " fault flag"}, {31'b0, resp_fault}, {31'b0, exp_fault});
        if (exp_fault) check(resp_kind == exp_kind, {req, " fault kind"}, {30'b0, resp_kind}, {30'b0, exp_kind});
        else           check(resp_paddr == exp_pa, {req, " physical address"}, resp_paddr, exp_pa);
        for (int i = 0; i < hold; i++) begin
            logic [31:0] pa;
            pa = resp_paddr;
            @(negedge clk);
            check(resp_valid && (resp_paddr == pa) && !req_ready, "R10 response held", resp_paddr, pa);
        end
        resp_ready = 1'b1;
        @(negedge clk);
        resp_ready = 1'b0;
        check(req_ready && !resp_valid, "R10 idle after response taken", {30'b0, req_ready, resp_valid}, 32'h2);
        check(rd_count == exp_reads, {req, " read count"}, rd_count, exp_reads);
        if (exp_reads >= 1) check(rd_log[0] == a0, "R2 first read address", rd_log[0], a0);
        if (exp_reads >= 2) check(rd_log[1] == a1, "R5 second read address", rd_log[1], a1);
    endtask

    task automatic test_reset();
        check(req_ready && !resp_valid && !mem_rd_valid, "R1 reset state",
              {29'b0, req_ready, resp_valid, mem_rd_valid}, 32'h4);
    endtask

    task automatic test_read_ok();
        run_walk("R7", 32'h00C0_5ABC, 1'b0, 1'b0, 2'd0, 32'hABCD_3ABC, 2, 32'h0001_000C, 32'h0002_0014, 0);
    endtask

    task automatic test_write_ok();
        // outer entry has bit 1 clear: must not matter (R8)
        run_walk("R8 write allowed", 32'h00C0_5123, 1'b1, 1'b0, 2'd0, 32'hABCD_3123, 2, 32'h0001_000C, 32'h0002_0014, 0);
    endtask

    task automatic test_write_denied();
        run_walk("R8 write refused", 32'h00C0_6010, 1'b1, 1'b1, 2'd3, 32'h0, 2, 32'h0001_000C, 32'h0002_0018, 0);
        run_walk("R8 read of read-only", 32'h00C0_6010, 1'b0, 1'b0, 2'd0, 32'h1234_5010, 2, 32'h0001_000C, 32'h0002_0018, 0);
    endtask

    task automatic test_outer_invalid();
        run_walk("R4", 32'h0100_0000, 1'b0, 1'b1, 2'd1, 32'h0, 1, 32'h0001_0010, 32'h0, 0);
    endtask

    task automatic test_inner_invalid();
        run_walk("R6", 32'h00C0_7000, 1'b0, 1'b1, 2'd2, 32'h0, 2, 32'h0001_000C, 32'h0002_001C, 0);
    endtask

    task automatic test_length();
        run_walk("R3 beyond length", 32'h0400_0000, 1'b0, 1'b1, 2'd0, 32'h0, 0, 32'h0, 32'h0, 0);
        run_walk("R3 last index walks", 32'h03FF_FFFF, 1'b0, 1'b0, 2'd0, 32'hFFFF_FFFF, 2, 32'h0001_003C, 32'h0004_0FFC, 0);
        tbl_len = 11'd0;
        run_walk("R3 zero length", 32'h0000_0000, 1'b0, 1'b1, 2'd0, 32'h0, 0, 32'h0, 32'h0, 0);
        tbl_len = 11'd16;
    endtask

    task automatic test_stall_and_hold();
        ready_delay = 3;
        rsp_delay   = 4;
        run_walk("R9 stalled memory", 32'h00C0_5001, 1'b0, 1'b0, 2'd0, 32'hABCD_3001, 2, 32'h0001_000C, 32'h0002_0014, 3);
        ready_delay = 0;
        rsp_delay   = 0;
    endtask

    initial begin
        mem_img[32'h0001_000C] = 32'h0002_0001;  // outer idx 3: inner table 0x20000, valid, bit1 clear
        mem_img[32'h0001_0010] = 32'h0003_0002;  // outer idx 4: invalid
        mem_img[32'h0001_003C] = 32'h0004_0001;  // outer idx 15
        mem_img[32'h0002_0014] = 32'hABCD_3003;  // inner idx 5: valid, writable
        mem_img[32'h0002_0018] = 32'h1234_5001;  // inner idx 6: valid, read-only
        mem_img[32'h0002_001C] = 32'h5555_5002;  // inner idx 7: invalid
        mem_img[32'h0004_0FFC] = 32'hFFFF_F003;  // inner idx 1023
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_read_ok();
        test_write_ok();
        test_write_denied();
        test_outer_invalid();
        test_inner_invalid();
        test_length();
        test_stall_and_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (whole run) actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule